// File: doc/BRIEF.md
# Packed Subword Multiply-Add Unit

This block executes one packed multiply-add instruction per valid strobe. It decodes a 64-bit instruction word and takes three 32-bit operand values from the surrounding datapath. From the first two operands it picks an 8-bit or 16-bit piece. The second operand can be replaced by a 16-bit immediate carried in the instruction word. The block forms the product of the two pieces, adds the third operand and can shift the sum right to rescale a fixed-point value. It then either clamps the value to the 32-bit range or lets it wrap, and writes the outcome to a registered result.

Each operand carries its own signedness bit. When either of them is signed the whole operation runs signed: the addend is read as a signed value, the shift is arithmetic and the clamp limits are the signed 32-bit ones. When neither is signed, all three are treated as unsigned. An instruction can also update a zero flag and a sign flag from its result. Two piece codes are not computed. One of them forces a zero result. The other also raises an unsupported-mode flag that comes out with the result.

Top module: `psma_unit`

## Requirements
- R1: While reset is held, and at the first sample after it, out_valid, result, flag_zero, flag_sign and unsupported are all 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. result and the flags appear in that same cycle. result holds its value through cycles without in_valid.
- R3: When an operand's chunk bit is 0, its 2-bit select field k picks byte k: (reg >> 8k) & 0xFF. Operand A uses chunk bit 38 and select bits 37:36. Operand B uses chunk bit 30 and select bits 29:28.
- R4: When an operand's chunk bit is 1, select code 0 takes bits 15:0 of the register and select code 1 takes bits 31:16.
- R5: When instruction bit 50 is 0, B is the immediate in bits 35:20. It is sign-extended when bit 49 is 1 and zero-extended when bit 49 is 0. B's chunk and select bits then have no effect.
- R6: A is signed when bit 48 is 1 and B is signed when bit 49 is 1. A signed piece is sign-extended from its own width. The operation is signed when either bit is set. In that case operand C is read as signed, and otherwise as unsigned.
- R7: Shift field bits 52:51 act on A*B+C. Code 1 shifts it right by 7 and code 2 shifts it right by 15. Codes 0 and 3 leave it unshifted. The shift is arithmetic in signed operation and logical in unsigned operation.
- R8: When bit 55 is 1, the value is clamped to the 32-bit range: [-2^31, 2^31-1] for signed operation and [0, 2^32-1] for unsigned operation.
- R9: When bit 55 is 0, the result is the low 32 bits of the exact value, so it wraps.
- R10: When either operand is taken from a register with chunk bit 1 and select code 3, the result is 0 whatever the other inputs are.
- R11: When either operand is taken from a register with chunk bit 1 and select code 2, the result is 0 and unsupported is 1 in the out_valid cycle. unsupported is 0 in every other cycle.
- R12: When bit 47 is set, flag_zero is set to (result == 0) and flag_sign is set to result bit 31. When bit 47 is clear, both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 64 | Instruction word |
| opnd_a | input | 32 | Operand A register value |
| opnd_b | input | 32 | Operand B register value |
| opnd_c | input | 32 | Addend register value |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Registered result |
| flag_zero | output | 1 | Zero condition flag |
| flag_sign | output | 1 | Sign condition flag |
| unsupported | output | 1 | The instruction used the 32-bit piece code |

## Verification
The operation is combinational up to one output register. result, unsupported and both flags are therefore due at the first rising edge after the strobe, and out_valid rises at that same edge. Each scenario task drives its inputs on a falling edge. It raises in_valid for one cycle, then reads every output at the next falling edge, which lies half a period after the edge that loads them. The idle cycles that follow are sampled on falling edges too. At those samples the checks confirm that out_valid has dropped, that unsupported has dropped, that result is held, and that the flags are held when the condition-code bit was clear.

// File: rtl/psma_pkg.sv
// Package: psma_pkg
// Shared field positions, codes and the decoded-control type of the packed
// subword multiply-add unit. Assumes a 64-bit instruction word.
package psma_pkg;

    localparam int INSTR_W = 64;
    localparam int IMM_W   = 16;

    // Bit positions inside the instruction word
    localparam int POS_SAT        = 55;
    localparam int POS_SHIFT_LO   = 51;
    localparam int POS_B_FROM_REG = 50;
    localparam int POS_B_SIGNED   = 49;
    localparam int POS_A_SIGNED   = 48;
    localparam int POS_CC_EN      = 47;
    localparam int POS_A_CHUNK    = 38;
    localparam int POS_A_SEL_LO   = 36;
    localparam int POS_IMM_LO     = 20;
    localparam int POS_B_CHUNK    = 30;
    localparam int POS_B_SEL_LO   = 28;

    // Piece codes used when the chunk bit is set
    typedef enum logic [1:0] {
        PIECE_LO16  = 2'd0,
        PIECE_HI16  = 2'd1,
        PIECE_WORD  = 2'd2,
        PIECE_BAD   = 2'd3
    } piece_code_e;

    // Post-shift codes
    typedef enum logic [1:0] {
        SHIFT_NONE  = 2'd0,
        SHIFT_SMALL = 2'd1,
        SHIFT_LARGE = 2'd2,
        SHIFT_RSVD  = 2'd3
    } shift_code_e;

    typedef struct packed {
        logic               a_signed;
        logic               a_chunk;
        logic [1:0]         a_sel;
        logic               b_signed;
        logic               b_from_reg;
        logic               b_chunk;
        logic [1:0]         b_sel;
        shift_code_e        shift_sel;
        logic               cc_en;
        logic               saturate;
        logic [IMM_W-1:0]   imm;
    } psma_ctrl_t;

endpackage

// File: rtl/psma_decode.sv
// Module: psma_decode
// Pulls the control fields of a multiply-add instruction out of the
// instruction word. Pure combinational slicing; assumes the fixed positions
// held in psma_pkg.
module psma_decode
    import psma_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output psma_ctrl_t         ctrl
);

    // Slice every field from its fixed position
    always_comb begin
        ctrl.a_signed   = instr[POS_A_SIGNED];
        ctrl.a_chunk    = instr[POS_A_CHUNK];
        ctrl.a_sel      = instr[POS_A_SEL_LO +: 2];
        ctrl.b_signed   = instr[POS_B_SIGNED];
        ctrl.b_from_reg = instr[POS_B_FROM_REG];
        ctrl.b_chunk    = instr[POS_B_CHUNK];
        ctrl.b_sel      = instr[POS_B_SEL_LO +: 2];
        ctrl.shift_sel  = shift_code_e'(instr[POS_SHIFT_LO +: 2]);
        ctrl.cc_en      = instr[POS_CC_EN];
        ctrl.saturate   = instr[POS_SAT];
        ctrl.imm        = instr[POS_IMM_LO +: IMM_W];
    end

endmodule

// File: rtl/psma_subword_sel.sv
// Module: psma_subword_sel
// Extracts one byte or one 16-bit half from a register value and extends it
// to the accumulator width, signed or unsigned. It flags the 32-bit piece
// code as unsupported and the reserved code as invalid; both return zero.
// Assumes DATA_W is a multiple of 16 with four byte lanes.
module psma_subword_sel
    import psma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 64
) (
    input  logic                     [DATA_W-1:0] reg_val,
    input  logic                                  chunk,
    input  logic                     [1:0]        sel,
    input  logic                                  is_signed,
    output logic signed              [ACC_W-1:0]  val,
    output logic                                  is_invalid,
    output logic                                  is_unsup
);

    localparam int LANES  = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    logic [7:0]        lane [LANES];
    logic [HALF_W-1:0] half;

    // Split the register into byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = reg_val[g*8 +: 8];
    end

    // Choose the piece and extend it to the accumulator width
    always_comb begin
        val        = '0;
        is_invalid = 1'b0;
        is_unsup   = 1'b0;
        half       = '0;
        if (!chunk) begin
            val = {{(ACC_W-8){is_signed & lane[sel][7]}}, lane[sel]};
        end else begin
            case (piece_code_e'(sel))
                PIECE_LO16: begin
                    half = reg_val[HALF_W-1:0];
                    val  = {{(ACC_W-HALF_W){is_signed & half[HALF_W-1]}}, half};
                end
                PIECE_HI16: begin
                    half = reg_val[DATA_W-1:HALF_W];
                    val  = {{(ACC_W-HALF_W){is_signed & half[HALF_W-1]}}, half};
                end
                PIECE_WORD: is_unsup   = 1'b1;
                default:    is_invalid = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/psma_mac.sv
// Module: psma_mac
// Forms A*B+C at double width. It applies the optional right shift
// (arithmetic when signed, logical when unsigned), then either clamps to the
// 32-bit range or wraps. A force input replaces the outcome with zero.
// Assumes A and B are already extended to ACC_W and small enough that
// the product cannot overflow ACC_W.
module psma_mac
    import psma_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ACC_W     = 64,
    parameter int SHIFT_SML = 7,
    parameter int SHIFT_LRG = 15
) (
    input  logic signed [ACC_W-1:0]  a_val,
    input  logic signed [ACC_W-1:0]  b_val,
    input  logic        [DATA_W-1:0] c_val,
    input  logic                     signed_mode,
    input  shift_code_e              shift_sel,
    input  logic                     saturate,
    input  logic                     force_zero,
    output logic        [DATA_W-1:0] res
);

    localparam logic signed [ACC_W-1:0] SMAX =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SMIN =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] UMAX =
        {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

    logic signed [ACC_W-1:0] c_ext;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] clamped;

    // Extend the addend per the operation's signedness and add the product
    always_comb begin
        c_ext = {{(ACC_W-DATA_W){signed_mode & c_val[DATA_W-1]}}, c_val};
        sum   = a_val * b_val + c_ext;
    end

    // Fixed-point rescale of the sum
    always_comb begin
        case (shift_sel)
            SHIFT_SMALL: shifted = signed_mode ? (sum >>> SHIFT_SML)
                                               : $signed($unsigned(sum) >> SHIFT_SML);
            SHIFT_LARGE: shifted = signed_mode ? (sum >>> SHIFT_LRG)
                                               : $signed($unsigned(sum) >> SHIFT_LRG);
            default:     shifted = sum;
        endcase
    end

    // Clamp to the signed or unsigned 32-bit range when saturation is on
    always_comb begin
        clamped = shifted;
        if (saturate) begin
            if (signed_mode) begin
                if (shifted > SMAX)      clamped = SMAX;
                else if (shifted < SMIN) clamped = SMIN;
            end else begin
                if (shifted > UMAX)      clamped = UMAX;
                else if (shifted < 0)    clamped = '0;
            end
        end
    end

    // Final selection: forced zero or the low word
    always_comb begin
        res = force_zero ? '0 : clamped[DATA_W-1:0];
    end

endmodule

// File: rtl/psma_unit.sv
// Module: psma_unit
// Top of the packed subword multiply-add unit. It decodes the instruction
// and selects the A and B pieces (or the immediate for B). It computes the
// multiply-add and registers the result, valid, condition flags and
// unsupported-mode flag once. Assumes operands and instruction are stable
// in the cycle in_valid is high; the results are due one cycle later.
module psma_unit
    import psma_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SHIFT_SML = 7,
    parameter int SHIFT_LRG = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [63:0]        instr,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [DATA_W-1:0]  opnd_c,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               flag_zero,
    output logic               flag_sign,
    output logic               unsupported
);

    localparam int ACC_W = 2 * DATA_W;

    psma_ctrl_t              ctrl;
    logic signed [ACC_W-1:0] a_piece;
    logic signed [ACC_W-1:0] b_piece;
    logic signed [ACC_W-1:0] b_val;
    logic                    a_bad, a_unsup;
    logic                    b_bad, b_unsup;
    logic                    any_bad, any_unsup;
    logic                    signed_mode;
    logic [DATA_W-1:0]       mac_res;

    psma_decode u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    psma_subword_sel #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sel_a (
        .reg_val    (opnd_a),
        .chunk      (ctrl.a_chunk),
        .sel        (ctrl.a_sel),
        .is_signed  (ctrl.a_signed),
        .val        (a_piece),
        .is_invalid (a_bad),
        .is_unsup   (a_unsup)
    );

    psma_subword_sel #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sel_b (
        .reg_val    (opnd_b),
        .chunk      (ctrl.b_chunk),
        .sel        (ctrl.b_sel),
        .is_signed  (ctrl.b_signed),
        .val        (b_piece),
        .is_invalid (b_bad),
        .is_unsup   (b_unsup)
    );

    // Pick the B source and merge the forced-zero conditions
    always_comb begin
        b_val       = ctrl.b_from_reg ? b_piece
                    : {{(ACC_W-IMM_W){ctrl.b_signed & ctrl.imm[IMM_W-1]}}, ctrl.imm};
        any_bad     = a_bad   | (ctrl.b_from_reg & b_bad);
        any_unsup   = a_unsup | (ctrl.b_from_reg & b_unsup);
        signed_mode = ctrl.a_signed | ctrl.b_signed;
    end

    psma_mac #(
        .DATA_W    (DATA_W),
        .ACC_W     (ACC_W),
        .SHIFT_SML (SHIFT_SML),
        .SHIFT_LRG (SHIFT_LRG)
    ) u_mac (
        .a_val       (a_piece),
        .b_val       (b_val),
        .c_val       (opnd_c),
        .signed_mode (signed_mode),
        .shift_sel   (ctrl.shift_sel),
        .saturate    (ctrl.saturate),
        .force_zero  (any_bad | any_unsup),
        .res         (mac_res)
    );

    // Output register: valid, result, unsupported flag and condition codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            flag_zero   <= 1'b0;
            flag_sign   <= 1'b0;
            unsupported <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            unsupported <= in_valid & any_unsup;
            if (in_valid) begin
                result <= mac_res;
                if (ctrl.cc_en) begin
                    flag_zero <= (mac_res == '0);
                    flag_sign <= mac_res[DATA_W-1];
                end
            end
        end
    end

    // Valid follows the strobe by exactly one cycle
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // Result holds without a strobe
    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // Reserved piece code forces a zero result
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_bad) |=> (result == '0));
    // Unsupported flag only with valid and a zero result
    assert_unsup_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (out_valid && result == '0));
    // Flags follow the result when updated
    assert_flags_track_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl.cc_en) |=> (flag_zero == (result == '0)) && (flag_sign == result[DATA_W-1]));
    // Flags hold otherwise
    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && ctrl.cc_en) |=> $stable({flag_zero, flag_sign}));

endmodule

// File: tb/psma_unit_tb.sv
// Directed bench for psma_unit: one task per scenario, each checking its own
// results at the falling edge after the loading clock edge.
module psma_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] instr = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        out_valid, flag_zero, flag_sign, unsupported;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psma_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .instr       (instr),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .opnd_c      (opnd_c),
        .out_valid   (out_valid),
        .result      (result),
        .flag_zero   (flag_zero),
        .flag_sign   (flag_sign),
        .unsupported (unsupported)
    );

    function automatic logic [63:0] mk(
        input logic sa, input logic ca, input logic [1:0] ta,
        input logic sb, input logic rb, input logic cb, input logic [1:0] tb,
        input logic [1:0] sh, input logic cc, input logic sat, input logic [15:0] imm);
        logic [63:0] w = '0;
        w[48] = sa; w[38] = ca; w[37:36] = ta;
        w[49] = sb; w[50] = rb; w[35:20] = imm;
        w[30] = w[30] | cb; w[29:28] = w[29:28] | tb;
        w[52:51] = sh; w[47] = cc; w[55] = sat;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Issue one instruction and leave the bench at the falling edge where results are due
    task automatic issue(input logic [63:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        instr = w; opnd_a = a; opnd_b = b; opnd_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 flags", {30'd0, flag_zero, flag_sign}, 32'd0);
        chk("R1 unsupported", {31'd0, unsupported}, 32'd0);
    endtask

    task automatic t_bytes;
        issue(mk(0,0,2'd2, 0,1,0,2'd3, 2'd0,0,0,16'h0), 32'h11223344, 32'hAABBCCDD, 32'd5);
        chk("R3 byte2*byte3+5", result, 32'h00001699);
        chk("R2 valid after strobe", {31'd0, out_valid}, 32'd1);
        issue(mk(0,0,2'd0, 0,1,0,2'd1, 2'd0,0,0,16'h0), 32'h11223344, 32'hAABBCCDD, 32'd0);
        chk("R3 byte0*byte1", result, 32'h00003630);
        @(negedge clk);
        chk("R2 valid drops", {31'd0, out_valid}, 32'd0);
        chk("R2 result held", result, 32'h00003630);
    endtask

    task automatic t_halves;
        issue(mk(0,1,2'd1, 0,1,1,2'd0, 2'd0,0,0,16'h0), 32'h12340005, 32'hFFFF0003, 32'h10);
        chk("R4 hi16*lo16+16", result, 32'h000036AC);
    endtask

    task automatic t_imm;
        issue(mk(0,0,2'd0, 0,0,0,2'd0, 2'd0,0,0,16'hFFFE), 32'd2, 32'hDEADBEEF, 32'd0);
        chk("R5 zero-extended imm", result, 32'h0001FFFC);
        issue(mk(0,0,2'd0, 1,0,0,2'd0, 2'd0,0,0,16'hFFFE), 32'd2, 32'hDEADBEEF, 32'd0);
        chk("R5 sign-extended imm", result, 32'hFFFFFFFC);
        // imm 0x0700 places 1 on the B chunk bit and 3 on B select: ignored
        issue(mk(0,0,2'd0, 0,0,0,2'd0, 2'd0,0,0,16'h0700), 32'd1, 32'd0, 32'd0);
        chk("R5 B type bits ignored with imm", result, 32'h00000700);
    endtask

    task automatic t_signed;
        issue(mk(1,0,2'd0, 0,1,0,2'd0, 2'd0,0,0,16'h0), 32'h000000FF, 32'd3, 32'hFFFFFFF6);
        chk("R6 signed A, signed C", result, 32'hFFFFFFF3);
        issue(mk(0,0,2'd0, 0,1,0,2'd0, 2'd0,0,0,16'h0), 32'h000000FF, 32'd3, 32'hFFFFFFF6);
        chk("R9 unsigned wrap", result, 32'h000002F3);
        issue(mk(0,0,2'd0, 0,1,0,2'd0, 2'd0,0,1,16'h0), 32'h000000FF, 32'd3, 32'hFFFFFFF6);
        chk("R8 unsigned clamp", result, 32'hFFFFFFFF);
    endtask

    task automatic t_shift;
        issue(mk(0,1,2'd0, 0,0,0,2'd0, 2'd1,0,0,16'h0100), 32'h00004000, 32'd0, 32'd0);
        chk("R7 shift 7", result, 32'h00008000);
        issue(mk(0,1,2'd0, 0,0,0,2'd0, 2'd2,0,0,16'h0100), 32'h00004000, 32'd0, 32'd0);
        chk("R7 shift 15", result, 32'h00000080);
        issue(mk(0,1,2'd0, 0,0,0,2'd0, 2'd0,0,0,16'h0100), 32'h00004000, 32'd0, 32'd0);
        chk("R7 shift code 0", result, 32'h00400000);
        issue(mk(0,1,2'd0, 0,0,0,2'd0, 2'd3,0,0,16'h0100), 32'h00004000, 32'd0, 32'd0);
        chk("R7 shift code 3", result, 32'h00400000);
        issue(mk(1,1,2'd0, 0,0,0,2'd0, 2'd1,0,0,16'h0100), 32'h0000FFFF, 32'd0, 32'd0);
        chk("R7 arithmetic shift", result, 32'hFFFFFFFE);
    endtask

    task automatic t_sat;
        issue(mk(1,1,2'd0, 1,0,0,2'd0, 2'd0,0,1,16'h7FFF), 32'h00007FFF, 32'd0, 32'h7FFFFFFF);
        chk("R8 signed high clamp", result, 32'h7FFFFFFF);
        issue(mk(1,1,2'd0, 1,0,0,2'd0, 2'd0,0,0,16'h7FFF), 32'h00007FFF, 32'd0, 32'h7FFFFFFF);
        chk("R9 signed wrap", result, 32'hBFFF0000);
        issue(mk(1,1,2'd0, 1,0,0,2'd0, 2'd0,0,1,16'h7FFF), 32'h00008000, 32'd0, 32'h80000000);
        chk("R8 signed low clamp", result, 32'h80000000);
    endtask

    task automatic t_reserved;
        issue(mk(0,1,2'd3, 0,0,0,2'd0, 2'd0,0,0,16'h0005), 32'h12345678, 32'd0, 32'h1234);
        chk("R10 A reserved code", result, 32'd0);
        chk("R10 no unsupported flag", {31'd0, unsupported}, 32'd0);
        issue(mk(0,0,2'd0, 0,1,1,2'd3, 2'd0,0,0,16'h0), 32'h00000007, 32'h00050005, 32'h99);
        chk("R10 B reserved code", result, 32'd0);
    endtask

    task automatic t_unsup;
        issue(mk(0,1,2'd2, 0,0,0,2'd0, 2'd0,0,0,16'h0003), 32'h00000004, 32'd0, 32'h55);
        chk("R11 result zero", result, 32'd0);
        chk("R11 flag with valid", {31'd0, unsupported, out_valid}, 32'd3);
        @(negedge clk);
        chk("R11 flag drops", {31'd0, unsupported}, 32'd0);
    endtask

    task automatic t_cc;
        issue(mk(0,1,2'd3, 0,0,0,2'd0, 2'd0,1,0,16'h0), 32'd1, 32'd0, 32'd1);
        chk("R12 zero flag set", {30'd0, flag_zero, flag_sign}, 32'd2);
        issue(mk(1,0,2'd0, 0,0,0,2'd0, 2'd0,1,0,16'h0001), 32'h00000080, 32'd0, 32'd0);
        chk("R12 sign flag set", {30'd0, flag_zero, flag_sign}, 32'd1);
        issue(mk(0,0,2'd0, 0,0,0,2'd0, 2'd0,0,0,16'h0001), 32'h00000009, 32'd0, 32'd0);
        chk("R12 flags held, result", result, 32'd9);
        chk("R12 flags held", {30'd0, flag_zero, flag_sign}, 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_bytes;
        t_halves;
        t_imm;
        t_signed;
        t_shift;
        t_sat;
        t_reserved;
        t_unsup;
        t_cc;
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule